// File: doc/BRIEF.md
# Self-Scrubbing Triplicated Register

This block holds a word of state in three identical copies and presents their bit-wise two-out-of-three vote on its output. The copies are never left alone between loads: on every clock edge that does not load new data, each copy is rewritten from a voter of its own that sees all three copies. A single bit upset in any one copy is therefore outvoted at the output in the cycle it is present and repaired at the next edge, so upsets cannot pile up across cycles into a double error.

A disagreement flag reports every cycle in which the three copies are not identical, and a saturating counter records how many such cycles have been repaired. Three fault-injection masks, one per copy, let a test flip chosen bits of one or more copies at a chosen edge. A build-time option replaces the common load path with a time-staggered capture: the three copies are loaded with the input as it is now, as it was a set number of cycles ago, and as it was twice that number of cycles ago. A glitch on the input that lasts for fewer cycles than that spacing lands in at most one copy and is voted away.

Top module: `tmr_scrub_reg`

## Requirements
- R1: While reset is low (asynchronous, active low), all three copies are zero, so `dout` is 0, `mismatch` is 0 and `upset_count` is 0.
- R2: `dout` bit i is 1 exactly when at least two of the three copies hold 1 in bit i (per-bit lookup over copies c,b,a from 000 to 111 gives 0,0,0,1,0,1,1,1).
- R3: With staggering off, an edge with `load` high writes `din` into all three copies; `dout` equals that `din` after the edge.
- R4: An edge with `load` low and no injection leaves `dout` unchanged.
- R5: An upset in a single copy does not change `dout`, and the next edge without load or injection rewrites all copies from their voters so that they agree again.
- R6: `mismatch` is 1 in exactly those cycles where the three copies are not all equal.
- R7: `upset_count` increases by one at each edge that ends a cycle with `mismatch` high, and is otherwise unchanged.
- R8: `upset_count` saturates at its all-ones value and stays there.
- R9: `inj_a`, `inj_b` and `inj_c` are XORed into the value written to copy a, b and c respectively at the edge where they are nonzero, on load edges as well as refresh edges; they act for that edge only.
- R10: With staggering on (spacing D cycles), a load edge writes copy a from `din`, copy b from `din` of D edges earlier and copy c from `din` of 2D edges earlier, so a one-cycle input glitch in any one of those samples does not reach `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Write new data into the copies at this edge |
| din | input | W | Data to store |
| inj_a | input | W | Bit flips applied to copy a at this edge |
| inj_b | input | W | Bit flips applied to copy b at this edge |
| inj_c | input | W | Bit flips applied to copy c at this edge |
| dout | output | W | Bit-wise majority of the three copies |
| mismatch | output | 1 | Copies are not all equal in this cycle |
| upset_count | output | CNT_W | Saturating count of repaired disagreement cycles |

## Verification
Every result of this block is due exactly one edge after its cause: a load, an injection or a refresh shows in `dout` and `mismatch` after the edge that takes it, and the counter reflects a disagreement cycle only after the edge that closes that cycle. The bench drives inputs and samples outputs one nanosecond after each rising edge, so each sample sees the state written by the edge just past, and its own model advances the expected count by one tick after every cycle it predicted as disagreeing. In staggered mode, the delayed samples are counted in edges from the point where the input was presented, and the load edge is placed so that the glitch falls in the intended copy.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // Two-out-of-three vote, bit by bit.
  function automatic logic [63:0] vote3(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input logic [63:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  // Saturating increment for a counter of the given width.
  function automatic logic [63:0] sat_inc(input logic [63:0] v,
                                          input logic [63:0] max_v);
    return (v == max_v) ? v : v + 64'd1;
  endfunction
endpackage

// File: rtl/tmr_voter.sv
`timescale 1ns/1ps
module tmr_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  localparam int PAD = 64 - W;
  logic [63:0] wide;
  always_comb wide = tmr_pkg::vote3({{PAD{1'b0}}, a}, {{PAD{1'b0}}, b}, {{PAD{1'b0}}, c});
  assign y = wide[W-1:0];
endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture #(
  parameter int W       = 8,
  parameter bit STAGGER = 1'b0,
  parameter int DLY     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] s_a,
  output logic [W-1:0] s_b,
  output logic [W-1:0] s_c
);
  localparam int DEPTH = 2 * DLY;

  generate
    if (STAGGER) begin : g_stag
      logic [DEPTH-1:0][W-1:0] hist_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hist_q <= '0;
        end else begin
          hist_q[0] <= din;
          for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
        end
      end
      assign s_a = din;
      assign s_b = hist_q[DLY-1];
      assign s_c = hist_q[DEPTH-1];
    end else begin : g_flat
      assign s_a = din;
      assign s_b = din;
      assign s_c = din;
    end
  endgenerate
endmodule

// File: rtl/tmr_upset_counter.sv
`timescale 1ns/1ps
module tmr_upset_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam int PAD = 64 - CNT_W;
  logic [63:0] nxt;
  always_comb nxt = tmr_pkg::sat_inc({{PAD{1'b0}}, count}, {{PAD{1'b0}}, MAXV});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (evt) count <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/tmr_scrub_reg.sv
`timescale 1ns/1ps
module tmr_scrub_reg #(
  parameter int W       = 8,
  parameter int CNT_W   = 16,
  parameter bit STAGGER = 1'b0,
  parameter int DLY     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     din,
  input  logic [W-1:0]     inj_a,
  input  logic [W-1:0]     inj_b,
  input  logic [W-1:0]     inj_c,
  output logic [W-1:0]     dout,
  output logic             mismatch,
  output logic [CNT_W-1:0] upset_count
);
  localparam int NCOPY = 3;

  logic [NCOPY-1:0][W-1:0] copy_q;
  logic [NCOPY-1:0][W-1:0] refresh_v;
  logic [NCOPY-1:0][W-1:0] cap_v;
  logic [NCOPY-1:0][W-1:0] flip_v;
  logic                    scrub_evt;

  assign flip_v = {inj_c, inj_b, inj_a};

  tmr_capture #(.W(W), .STAGGER(STAGGER), .DLY(DLY)) u_cap (
    .clk(clk), .rst_n(rst_n), .din(din),
    .s_a(cap_v[0]), .s_b(cap_v[1]), .s_c(cap_v[2])
  );

  // One private refresh voter per copy, so no single voter feeds all three.
  generate
    for (genvar k = 0; k < NCOPY; k++) begin : g_copy
      tmr_voter #(.W(W)) u_refresh (
        .a(copy_q[0]), .b(copy_q[1]), .c(copy_q[2]), .y(refresh_v[k])
      );
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) copy_q[k] <= '0;
        else        copy_q[k] <= (load ? cap_v[k] : refresh_v[k]) ^ flip_v[k];
      end
    end
  endgenerate

  tmr_voter #(.W(W)) u_out (
    .a(copy_q[0]), .b(copy_q[1]), .c(copy_q[2]), .y(dout)
  );

  assign scrub_evt = (copy_q[0] != copy_q[1]) || (copy_q[1] != copy_q[2]);
  assign mismatch  = scrub_evt;

  tmr_upset_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .evt(scrub_evt), .count(upset_count)
  );
endmodule

// File: rtl/tmr_scrub_reg_chk.sv
`timescale 1ns/1ps
module tmr_scrub_reg_chk #(
  parameter int W       = 8,
  parameter int CNT_W   = 16,
  parameter bit STAGGER = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load,
  input logic [W-1:0]     din,
  input logic [W-1:0]     inj_a,
  input logic [W-1:0]     inj_b,
  input logic [W-1:0]     inj_c,
  input logic [W-1:0]     dout,
  input logic             mismatch,
  input logic [CNT_W-1:0] upset_count
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  logic no_inj;
  logic one_inj;
  assign no_inj  = (inj_a == '0) && (inj_b == '0) && (inj_c == '0);
  assign one_inj = $countones({|inj_a, |inj_b, |inj_c}) == 1;

  // R3
  load_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!STAGGER && load && no_inj) |=> (dout == $past(din)) && !mismatch);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && no_inj && !mismatch) |=> $stable(dout) && !mismatch);

  // R5
  single_upset_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && one_inj && !mismatch) |=> $stable(dout));

  // R5
  scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && no_inj && mismatch) |=> !mismatch);

  // R7
  count_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && upset_count != MAXV) |=> upset_count == $past(upset_count) + 1'b1);

  // R7
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> $stable(upset_count));

  // R8
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upset_count == MAXV) |=> upset_count == MAXV);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_state_chk: assert (dout == '0 && !mismatch && upset_count == '0);
    end
  end
endmodule

bind tmr_scrub_reg tmr_scrub_reg_chk #(.W(W), .CNT_W(CNT_W), .STAGGER(STAGGER)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .din(din),
  .inj_a(inj_a), .inj_b(inj_b), .inj_c(inj_c),
  .dout(dout), .mismatch(mismatch), .upset_count(upset_count)
);

// File: tb/tmr_scrub_reg_tb.sv
`timescale 1ns/1ps
module tmr_scrub_reg_tb;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // Plain instance
  logic         load = 0;
  logic [W-1:0] din = '0, ia = '0, ib = '0, ic = '0;
  logic [W-1:0] dout;
  logic         mis;
  logic [15:0]  cnt;

  // Staggered instance, small counter
  logic         lds = 0;
  logic [W-1:0] ds = '0, sa = '0, sb = '0, sc = '0;
  logic [W-1:0] douts;
  logic         miss;
  logic [3:0]   cnts;

  tmr_scrub_reg #(.W(W), .CNT_W(16), .STAGGER(1'b0), .DLY(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din),
    .inj_a(ia), .inj_b(ib), .inj_c(ic),
    .dout(dout), .mismatch(mis), .upset_count(cnt));

  tmr_scrub_reg #(.W(W), .CNT_W(4), .STAGGER(1'b1), .DLY(2)) u_dut_stag (
    .clk(clk), .rst_n(rst_n), .load(lds), .din(ds),
    .inj_a(sa), .inj_b(sb), .inj_c(sc),
    .dout(douts), .mismatch(miss), .upset_count(cnts));

  int n_chk = 0;
  int n_fail = 0;
  int exp_cnt = 0, exp_cnt_s = 0;
  bit exp_mis = 0, exp_mis_s = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge and update the counter model from the cycle just closed.
  task automatic tick();
    @(posedge clk);
    #1;
    if (exp_mis && exp_cnt < 65535) exp_cnt++;
    if (exp_mis_s && exp_cnt_s < 15) exp_cnt_s++;
    exp_mis = 0;
    exp_mis_s = 0;
  endtask

  function automatic int maj(input int a, input int b, input int c);
    int r = 0;
    for (int i = 0; i < W; i++)
      if ((((a >> i) & 1) + ((b >> i) & 1) + ((c >> i) & 1)) >= 2) r |= (1 << i);
    return r;
  endfunction

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cur;
    // R1: reset state
    din = 4'hF; ds = 4'hF;
    repeat (3) begin @(posedge clk); #1; end
    chk("R1 dout", dout, 0); chk("R1 mismatch", mis, 0); chk("R1 count", cnt, 0);
    chk("R1 stag dout", douts, 0);
    rst_n = 1'b1;
    din = '0; ds = '0;
    tick();

    // R3/R4: every value loaded, then held while din changes
    for (int v = 0; v < 16; v++) begin
      load = 1; din = v[W-1:0]; tick();
      chk("R3 load", dout, v); chk("R6 no mismatch after load", mis, 0);
      load = 0; din = ~v[W-1:0]; tick();
      chk("R4 hold", dout, v);
    end
    cur = 15;

    // R5/R6/R7/R9: single-copy upsets, every copy, every mask
    for (int k = 0; k < 3; k++) begin
      for (int m = 1; m < 16; m++) begin
        ia = (k == 0) ? m[W-1:0] : '0;
        ib = (k == 1) ? m[W-1:0] : '0;
        ic = (k == 2) ? m[W-1:0] : '0;
        tick();
        ia = '0; ib = '0; ic = '0;
        chk("R5 upset masked", dout, cur);
        chk("R9 upset written", mis, 1);
        chk("R7 count before repair", cnt, exp_cnt);
        exp_mis = 1;
        tick();
        chk("R5 scrubbed", mis, 0);
        chk("R5 value kept", dout, cur);
        chk("R7 count after repair", cnt, exp_cnt);
      end
    end

    // R2: voter truth table on bit 0, every flip pattern, both stored levels
    for (int q = 0; q < 2; q++) begin
      cur = q ? 15 : 0;
      load = 1; din = cur[W-1:0]; tick(); load = 0;
      for (int p = 0; p < 8; p++) begin
        int b0, ca, cb, cc, e;
        ca = cur ^ (p & 1); cb = cur ^ ((p >> 1) & 1); cc = cur ^ ((p >> 2) & 1);
        e = maj(ca, cb, cc);
        ia = {3'b0, p[0]}; ib = {3'b0, p[1]}; ic = {3'b0, p[2]};
        tick();
        ia = '0; ib = '0; ic = '0;
        b0 = (p != 0 && p != 7) ? 1 : 0;
        chk("R2 vote", dout, e);
        chk("R6 flag", mis, b0);
        exp_mis = b0[0];
        tick();
        chk("R2 refreshed", dout, e);
        chk("R6 flag clear", mis, 0);
        chk("R7 count", cnt, exp_cnt);
        cur = e;
      end
    end

    // R9: injection on a load edge
    load = 1; din = 4'h5; ib = 4'h2; tick();
    load = 0; ib = '0;
    chk("R9 load+inject dout", dout, 5); chk("R9 load+inject flag", mis, 1);
    exp_mis = 1; tick();
    chk("R9 repaired", mis, 0); chk("R9 value", dout, 5); chk("R7 count", cnt, exp_cnt);

    // R10: staggered capture, steady input
    ds = 4'h9; repeat (5) tick();
    lds = 1; tick(); lds = 0;
    chk("R10 steady", douts, 9); chk("R10 steady flag", miss, 0);

    // R10: glitch in the current sample (copy a)
    ds = 4'h6; lds = 1; tick(); lds = 0; ds = 4'h9;
    chk("R10 glitch a", douts, 9); chk("R10 glitch a flag", miss, 1);
    exp_mis_s = 1; tick(); chk("R10 a scrubbed", miss, 0);
    repeat (4) tick();

    // R10: glitch lands in the D-delayed sample (copy b)
    ds = 4'h6; tick(); ds = 4'h9; tick();
    lds = 1; tick(); lds = 0;
    chk("R10 glitch b", douts, 9); chk("R10 glitch b flag", miss, 1);
    exp_mis_s = 1; tick(); chk("R10 b scrubbed", miss, 0);
    repeat (4) tick();

    // R10: glitch lands in the 2D-delayed sample (copy c)
    ds = 4'h6; tick(); ds = 4'h9; repeat (3) tick();
    lds = 1; tick(); lds = 0;
    chk("R10 glitch c", douts, 9); chk("R10 glitch c flag", miss, 1);
    exp_mis_s = 1; tick(); chk("R10 c scrubbed", miss, 0);
    chk("R7 stag count", cnts, exp_cnt_s);

    // R8: drive the 4-bit counter past its top
    for (int i = 0; i < 20; i++) begin
      sc = 4'h8; tick(); sc = '0;
      exp_mis_s = 1; tick();
    end
    chk("R8 saturated", cnts, 15);
    chk("R8 model", cnts, exp_cnt_s);
    chk("R5 stag value kept", douts, 9);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule